// File: doc/BRIEF.md
# Debug Watchpoint Break Unit

This block watches a monitored access bus that reaches into a 12-bit register file address space. It raises a debug break request when an access hits a programmed watch address. A break can be enabled for reads, for writes or for both. It can also be narrowed so that only accesses carrying a programmed data byte cause a break. The break request is registered and lasts exactly one clock, in the cycle after the qualifying access.

Configuration sits in three byte-wide registers reached through a simple write port and a combinational read port. The control register holds the three qualifier enables and the upper four address bits. A second register holds the lower eight address bits, and a third holds the data byte to compare. A read-protect input locks the configuration. While it is high, software cannot set any qualifier enable, and enables that are already set are cleared on the next clock.

Top module: `wpt_break_unit`

## Requirements
- R1: After reset all three configuration registers read 0 and `brk_req` is 0.
- R2: Register select 0 is the control register, 1 is the low-address register, 2 is the watch-data register, and 3 reads 0 and ignores writes. In the control register, bit 7 enables the write break, bit 6 enables the read break, bit 5 enables the data qualifier, bit 4 always reads 0, and bits 3:0 are the upper nibble of the watch address.
- R3: A cycle with `acc_rd` high, with `acc_addr` equal to {control[3:0], low-address}, and with the read break enabled makes `brk_req` high in the next cycle, for that one cycle only.
- R4: A cycle with `acc_wr` high and a matching address, with the write break enabled, makes `brk_req` high in the next cycle, for that one cycle only.
- R5: No break follows a cycle with no strobe, a strobe whose kind is not enabled, or an address that differs in any bit.
- R6: With the data qualifier set, a matching access breaks only when `acc_data` equals the watch-data register. With it clear, `acc_data` is not compared.
- R7: With both the read and the write enables clear, no access causes a break, whatever the state of the data qualifier.
- R8: While `rd_prot` is high, a control write leaves bits 7:5 at 0 but still updates bits 3:0. Writes to the other registers are not affected.
- R9: In the clock after any cycle with `rd_prot` high, bits 7:5 of the control register are 0. An access that would otherwise have matched then raises no break.
- R10: An access is judged against the configuration held at the start of its cycle. A configuration write in the same cycle takes effect from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_prot | input | 1 | Read-protect lockout of the qualifier enables |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wsel | input | 2 | Register select for the write |
| cfg_wdata | input | 8 | Write data |
| cfg_rsel | input | 2 | Register select for the read |
| cfg_rdata | output | 8 | Read data (combinational) |
| acc_addr | input | 12 | Monitored access address |
| acc_rd | input | 1 | Monitored read strobe |
| acc_wr | input | 1 | Monitored write strobe |
| acc_data | input | 8 | Data read or written by the monitored access |
| brk_req | output | 1 | One-clock debug break request |

## Verification
Two things can fall in the same cycle. A configuration write can coincide with a monitored access to the watched address, and read protect can rise while the enables are set. The bench provokes the first by disabling the read enable in the same cycle as a matching read, which must still break. It then re-enables in the same cycle as a matching read, which must not break. It provokes the second by raising `rd_prot` with the read enable set, then checks both the read-back enables and the absence of a break on the next matching read.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

  // Register selects on the configuration port
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADLO = 2'd1,
    SEL_WDAT = 2'd2,
    SEL_NONE = 2'd3
  } wpt_sel_e;

  // Bit positions inside the control byte
  localparam int CTRL_WR_BIT = 7;
  localparam int CTRL_RD_BIT = 6;
  localparam int CTRL_DM_BIT = 5;
  localparam int CTRL_RSV_BIT = 4;
  localparam int CTRL_HI_W = 4;

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_prot,
  input  logic              we,
  input  logic [1:0]        wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        rsel,
  output logic [DATA_W-1:0] rdata,
  output logic              en_wr,
  output logic              en_rd,
  output logic              en_dm,
  output logic [ADDR_W-1:0] watch_addr,
  output logic [DATA_W-1:0] watch_data
);
  import wpt_pkg::*;

  localparam int HI_W = ADDR_W - LO_W;

  logic              en_wr_q, en_rd_q, en_dm_q;
  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_ctrl, wr_lo, wr_wd;

  // An enable bit survives a control write only without read protect
  function automatic logic gate_enable(input logic req, input logic prot);
    return req & ~prot;
  endfunction

  // Control byte as seen on the read port, reserved bit forced low
  function automatic logic [7:0] pack_ctrl(input logic w, input logic r,
                                           input logic d,
                                           input logic [CTRL_HI_W-1:0] hi);
    logic [7:0] v;
    v = '0;
    v[CTRL_WR_BIT] = w;
    v[CTRL_RD_BIT] = r;
    v[CTRL_DM_BIT] = d;
    v[CTRL_RSV_BIT] = 1'b0;
    v[CTRL_HI_W-1:0] = hi;
    return v;
  endfunction

  assign wr_ctrl = we && (wpt_sel_e'(wsel) == SEL_CTRL);
  assign wr_lo   = we && (wpt_sel_e'(wsel) == SEL_ADLO);
  assign wr_wd   = we && (wpt_sel_e'(wsel) == SEL_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_wr_q <= 1'b0;
      en_rd_q <= 1'b0;
      en_dm_q <= 1'b0;
      hi_q    <= '0;
    end else if (wr_ctrl) begin
      en_wr_q <= gate_enable(wdata[CTRL_WR_BIT], rd_prot);
      en_rd_q <= gate_enable(wdata[CTRL_RD_BIT], rd_prot);
      en_dm_q <= gate_enable(wdata[CTRL_DM_BIT], rd_prot);
      hi_q    <= wdata[HI_W-1:0];
    end else if (rd_prot) begin
      en_wr_q <= 1'b0;
      en_rd_q <= 1'b0;
      en_dm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wdata[LO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= '0;
    end else if (wr_wd) begin
      wd_q <= wdata;
    end
  end

  always_comb begin
    unique case (wpt_sel_e'(rsel))
      SEL_CTRL: rdata = DATA_W'(pack_ctrl(en_wr_q, en_rd_q, en_dm_q,
                                          CTRL_HI_W'(hi_q)));
      SEL_ADLO: rdata = DATA_W'(lo_q);
      SEL_WDAT: rdata = wd_q;
      default:  rdata = '0;
    endcase
  end

  assign en_wr      = en_wr_q;
  assign en_rd      = en_rd_q;
  assign en_dm      = en_dm_q;
  assign watch_addr = {hi_q, lo_q};
  assign watch_data = wd_q;

endmodule

// File: rtl/wpt_match.sv
module wpt_match #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [ADDR_W-1:0] watch_addr,
  input  logic [DATA_W-1:0] watch_data,
  input  logic              en_wr,
  input  logic              en_rd,
  input  logic              en_dm,
  output logic              addr_hit,
  output logic              data_ok,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              hit
);

  function automatic logic addr_equal(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  function automatic logic data_qualifies(input logic dm,
                                          input logic [DATA_W-1:0] seen,
                                          input logic [DATA_W-1:0] want);
    return !dm || (seen == want);
  endfunction

  assign addr_hit = addr_equal(acc_addr, watch_addr);
  assign data_ok  = data_qualifies(en_dm, acc_data, watch_data);
  assign rd_hit   = acc_rd && en_rd && addr_hit && data_ok;
  assign wr_hit   = acc_wr && en_wr && addr_hit && data_ok;
  assign hit      = rd_hit || wr_hit;

endmodule

// File: rtl/wpt_pulse.sv
module wpt_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic brk
);

  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else        brk_q <= hit;
  end

  assign brk = brk_q;

endmodule

// File: rtl/wpt_break_unit.sv
module wpt_break_unit #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_prot,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wsel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        cfg_rsel,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              brk_req
);

  logic              en_wr, en_rd, en_dm;
  logic [ADDR_W-1:0] watch_addr;
  logic [DATA_W-1:0] watch_data;
  logic              addr_hit, data_ok, rd_hit, wr_hit, hit;

  wpt_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_prot(rd_prot),
    .we(cfg_we), .wsel(cfg_wsel), .wdata(cfg_wdata),
    .rsel(cfg_rsel), .rdata(cfg_rdata),
    .en_wr(en_wr), .en_rd(en_rd), .en_dm(en_dm),
    .watch_addr(watch_addr), .watch_data(watch_data)
  );

  wpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_data(acc_data), .watch_addr(watch_addr), .watch_data(watch_data),
    .en_wr(en_wr), .en_rd(en_rd), .en_dm(en_dm),
    .addr_hit(addr_hit), .data_ok(data_ok),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .hit(hit)
  );

  wpt_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .hit(hit), .brk(brk_req)
  );

endmodule

// File: rtl/wpt_break_sva.sv
module wpt_break_sva #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_prot,
  input logic              cfg_we,
  input logic [1:0]        cfg_wsel,
  input logic [1:0]        cfg_rsel,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [DATA_W-1:0] acc_data,
  input logic              en_wr,
  input logic              en_rd,
  input logic              en_dm,
  input logic [DATA_W-1:0] watch_data,
  input logic              rd_hit,
  input logic              wr_hit,
  input logic              hit,
  input logic              brk_req
);

  AST_RSV_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsel == 2'd0) |-> (cfg_rdata[4] == 1'b0)); // R2

  AST_SEL3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rsel == 2'd3) |-> (cfg_rdata == '0)); // R2

  AST_RD_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> brk_req); // R3

  AST_WR_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> brk_req); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd && !acc_wr) |=> !brk_req); // R5

  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !brk_req); // R5

  AST_DATA_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_dm && (acc_data != watch_data)) |=> !brk_req); // R6

  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rd && !en_wr) |=> !brk_req); // R7

  AST_PROT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_prot && cfg_we && cfg_wsel == 2'd0) |=> (!en_wr && !en_rd && !en_dm)); // R8

  AST_PROT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_prot |=> (!en_wr && !en_rd && !en_dm)); // R9

endmodule

bind wpt_break_unit wpt_break_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rd_prot(rd_prot),
  .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
  .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
  .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_data(acc_data),
  .en_wr(en_wr), .en_rd(en_rd), .en_dm(en_dm), .watch_data(watch_data),
  .rd_hit(rd_hit), .wr_hit(wr_hit), .hit(hit), .brk_req(brk_req)
);

// File: tb/test_wpt_break_unit.sv
module test_wpt_break_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_prot = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_wsel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [1:0]  cfg_rsel = 2'd0;
  logic [7:0]  cfg_rdata;
  logic [11:0] acc_addr = 12'h000;
  logic        acc_rd = 1'b0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_data = 8'h00;
  logic        brk_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Bench model of the configuration
  logic [7:0] m_ctrl = 8'h00;
  logic [7:0] m_lo = 8'h00;
  logic [7:0] m_wd = 8'h00;

  always #5 clk = ~clk;

  wpt_break_unit i_wpt_break_unit (
    .clk(clk), .rst_n(rst_n), .rd_prot(rd_prot),
    .cfg_we(cfg_we), .cfg_wsel(cfg_wsel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_data(acc_data), .brk_req(brk_req)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_ctrl(input logic [7:0] d,
                                            input logic prot);
    logic [2:0] en;
    en = prot ? 3'b000 : d[7:5];
    return {en, 1'b0, d[3:0]};
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_ctrl = model_ctrl(d, rd_prot);
      2'd1: m_lo = d;
      2'd2: m_wd = d;
      default: ;
    endcase
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
    cfg_rsel = sel;
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic exp_brk(input logic [11:0] a, input logic r,
                                   input logic w, input logic [7:0] d);
    logic am, dok;
    am  = (a == {m_ctrl[3:0], m_lo});
    dok = !m_ctrl[5] || (d == m_wd);
    return am && dok && ((r && m_ctrl[6]) || (w && m_ctrl[7]));
  endfunction

  task automatic do_access(input logic [11:0] a, input logic r, input logic w,
                           input logic [7:0] d, input string req);
    logic e;
    e = exp_brk(a, r, w, d);
    @(negedge clk);
    acc_addr = a; acc_rd = r; acc_wr = w; acc_data = d;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    chk(req, brk_req, e);
    @(negedge clk);
    chk({req, " single pulse"}, brk_req, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [11:0] wa, a;
    logic [7:0] d;
    logic r, w;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_reg(2'd0, rv); chk("R1 ctrl", rv, 8'h00);
    rd_reg(2'd1, rv); chk("R1 addr lo", rv, 8'h00);
    rd_reg(2'd2, rv); chk("R1 watch data", rv, 8'h00);
    chk("R1 brk", brk_req, 1'b0);

    // R2: register map and reserved bit
    wr_reg(2'd0, 8'hFF); rd_reg(2'd0, rv); chk("R2 ctrl rsv", rv, 8'hEF);
    wr_reg(2'd1, 8'h5A); rd_reg(2'd1, rv); chk("R2 addr lo", rv, 8'h5A);
    wr_reg(2'd2, 8'hC3); rd_reg(2'd2, rv); chk("R2 watch data", rv, 8'hC3);
    wr_reg(2'd3, 8'h99); rd_reg(2'd3, rv); chk("R2 sel3 reads 0", rv, 8'h00);
    rd_reg(2'd0, rv); chk("R2 sel3 write ignored ctrl", rv, 8'hEF);
    rd_reg(2'd1, rv); chk("R2 sel3 write ignored lo", rv, 8'h5A);
    rd_reg(2'd2, rv); chk("R2 sel3 write ignored data", rv, 8'hC3);

    // Sweep: enables x upper nibble x access kind x address x data
    for (int en = 0; en < 8; en++) begin
      for (int h = 0; h < 16; h += 5) begin
        wr_reg(2'd0, {en[2:0], 1'b1, h[3:0]});
        wr_reg(2'd1, 8'(8'h30 + h * 7));
        wr_reg(2'd2, 8'(8'hA5 ^ h));
        rd_reg(2'd0, rv);
        chk("R2 ctrl readback", rv, {en[2:0], 1'b0, h[3:0]});
        wa = {m_ctrl[3:0], m_lo};
        for (int k = 0; k < 3; k++) begin
          for (int am = 0; am < 2; am++) begin
            for (int dm = 0; dm < 2; dm++) begin
              r = (k != 1);
              w = (k != 0);
              a = (am != 0) ? wa : (wa ^ (12'(1) << ((h + k + dm) % 12)));
              d = (dm != 0) ? m_wd : ~m_wd;
              if (!m_ctrl[7] && !m_ctrl[6]) tag = "R7";
              else if (am == 0) tag = "R5";
              else if (m_ctrl[5]) tag = "R6";
              else if (k == 0) tag = "R3";
              else tag = "R4";
              do_access(a, r, w, d, tag);
            end
          end
        end
        // R5: no strobe at the watched address
        do_access(wa, 1'b0, 1'b0, m_wd, "R5 no strobe");
      end
    end

    // R10: configuration write in the same cycle as an access
    wr_reg(2'd1, 8'h44);
    wr_reg(2'd0, 8'h42);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 8'h02;
    acc_addr = 12'h244; acc_rd = 1'b1; acc_data = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0; acc_rd = 1'b0;
    chk("R10 old enable still used", brk_req, 1'b1);
    m_ctrl = 8'h02;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wsel = 2'd0; cfg_wdata = 8'h42;
    acc_addr = 12'h244; acc_rd = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; acc_rd = 1'b0;
    chk("R10 new enable not yet used", brk_req, 1'b0);
    m_ctrl = 8'h42;
    do_access(12'h244, 1'b1, 1'b0, 8'h00, "R10 enable applied after write");

    // R9: protect rising with enables set
    @(negedge clk);
    rd_prot = 1'b1;
    @(negedge clk);
    rd_reg(2'd0, rv); chk("R9 enables cleared", rv, 8'h02);
    m_ctrl = 8'h02;
    do_access(12'h244, 1'b1, 1'b0, 8'h00, "R9 no break under protect");

    // R8: writes under protect
    wr_reg(2'd0, 8'hE9); rd_reg(2'd0, rv); chk("R8 enables masked", rv, 8'h09);
    wr_reg(2'd1, 8'h77); rd_reg(2'd1, rv); chk("R8 addr lo writable", rv, 8'h77);
    wr_reg(2'd2, 8'h3C); rd_reg(2'd2, rv); chk("R8 data writable", rv, 8'h3C);
    do_access(12'h977, 1'b1, 1'b1, 8'h3C, "R8 no break");
    rd_prot = 1'b0;
    wr_reg(2'd0, 8'hE9); rd_reg(2'd0, rv); chk("R8 enables after release", rv, 8'hE9);
    do_access(12'h977, 1'b0, 1'b1, 8'h3C, "R4 after release");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule